// File: doc/BRIEF.md
# DDR Write Burst Strobe Generator

This block sits on the controller side of a double-data-rate DRAM write path. It paces the data strobe, the data lanes and the byte-mask lanes of write bursts for a memory with a 2n prefetch. A command front end raises a write request together with a burst-length code (2, 4 or 8 elements) and a count of wanted elements. The block then pulls data and mask pairs from a source stream, one pair per core clock cycle. It drives one element on the rising strobe edge and the next on the falling edge, and it surrounds the burst with a low preamble and a low postamble. After that it switches off the output enables so that the strobe and data lanes float.

The strobe is modelled at half-cycle resolution inside the core clock domain. Every output bus carries two halves per core cycle, with index 0 for the first half and index 1 for the second. A new request may arrive on any clock edge. If it arrives while a burst is still running, the older burst is cut after the pairs it has already moved. If it arrives exactly when the older burst ends, the two bursts are joined. In both cases data keeps flowing with no gap, and the strobe keeps toggling with no preamble or postamble between the bursts. If the wanted count is odd, or smaller than the burst, the burst is still sent in whole pairs and the surplus elements carry an asserted mask.

Top module: `ddr_wr_strobe_gen`

## Requirements
- R1: After reset, and in any cycle with no burst activity around it, all strobe, enable, data and mask outputs are 0 and `src_take` is 0.
- R2: In the cycle right after the edge that samples `wr_req` (the preamble), with no data cycle just before it, `strobe_oe` is 2'b11 and `strobe_half` is 2'b00.
- R3: One core cycle after the sampling edge, the first rising strobe edge occurs. `strobe_half` is 2'b01 (high in the first half, low in the second) and `strobe_oe` is 2'b11. Element 0 (the low `DW` bits of the taken pair) is on `lane_data[DW-1:0]`, and element 1 (the high `DW` bits) is on the upper half.
- R4: `wr_bl` code 0, 1 and 2 give 1, 2 and 4 data cycles (2, 4 and 8 elements). Code 3 is treated as 8 elements. Each data cycle shows the next source pair with strobe 2'b01.
- R5: After the last data cycle, if no request follows, there is one postamble cycle with `strobe_half` 2'b00 and `strobe_oe` 2'b01. All enables are 0 after that.
- R6: A request sampled exactly when the running burst has moved all of its pairs joins the two bursts. The data cycles run back to back with no preamble or postamble between them.
- R7: A request sampled k cycles after the previous one, with k smaller than the previous burst's pair count, cuts that burst after k pairs. The new burst's data follows at once.
- R8: When the new request's preamble cycle falls on the old burst's postamble cycle, that cycle shows `strobe_half` 2'b00 and `strobe_oe` 2'b11.
- R9: With wanted count n (`wr_len`; 0 or a value above the burst length means the whole burst), every element with index n or higher in the burst has all of its mask bits set. Elements below n carry the source mask bits unchanged.
- R10: `src_take` is 1 exactly in those cycles whose following cycle is a data cycle. The pair on `src_data` and `src_mask` in that cycle is the one driven in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, sampled on the rising edge |
| wr_bl | input | 2 | Burst-length code: 0=2, 1=4, 2 or 3=8 elements |
| wr_len | input | 4 | Wanted element count, 0 = whole burst |
| src_data | input | 2*DW | Next data pair, element 0 in the low half |
| src_mask | input | 2*MW | Next mask pair, element 0 in the low half |
| src_take | output | 1 | The current source pair is consumed at the next edge |
| strobe_half | output | 2 | Strobe level in the first (bit 0) and second (bit 1) half-cycle |
| strobe_oe | output | 2 | Strobe and lane output enable per half-cycle |
| lane_data | output | 2*DW | Data elements per half-cycle |
| lane_mask | output | 2*MW | Mask bits per half-cycle |

## Verification
Isolated requests with every burst code separate the preamble, data and postamble phases and show each code's pair count. Directed pairs of requests spaced one, two and three cycles apart tell truncation, joining and a merged postamble/preamble apart from each other. Odd, short, zero and oversized wanted counts separate padding masks from masks passed through from the source. A long random stream with random spacing, codes and counts then mixes all of these overlaps, and each cycle is compared with a bench model that picks, for that cycle, the latest request still covering it.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int MAX_BL = 8;
    localparam int MAX_PAIRS = MAX_BL / 2;
    localparam int PAIR_W = $clog2(MAX_PAIRS + 1);
    localparam int LEN_W = $clog2(MAX_BL + 1);

    typedef logic [PAIR_W-1:0] pair_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [1:0] {
        BL_TWO   = 2'd0,
        BL_FOUR  = 2'd1,
        BL_EIGHT = 2'd2,
        BL_ALT8  = 2'd3
    } bl_code_e;

    // burst state: pairs still to pull and wanted elements left
    typedef struct packed {
        pair_t pairs;
        len_t  want;
    } ctrl_st_t;

    // strobe level and enable, bit 0 = first half-cycle
    typedef struct packed {
        logic [1:0] level;
        logic [1:0] oe;
    } strb_st_t;

    function automatic pair_t pairs_for(input logic [1:0] code);
        case (bl_code_e'(code))
            BL_TWO:  return pair_t'(1);
            BL_FOUR: return pair_t'(2);
            default: return pair_t'(MAX_PAIRS);
        endcase
    endfunction

    function automatic len_t eff_len(input logic [1:0] code, input len_t n);
        len_t limit;
        limit = len_t'(pairs_for(code)) << 1;
        return ((n == '0) || (n > limit)) ? limit : n;
    endfunction

endpackage

// File: rtl/wbs_ctrl.sv
module wbs_ctrl
    import wbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] bl_code,
    input  len_t       len,
    output logic       take,
    output logic [1:0] pad,
    output logic       pend_next
);

    ctrl_st_t s_d, s_q;

    assign take = (s_q.pairs != '0);

    always_comb begin
        s_d = s_q;
        pad = 2'b00;
        if (take) begin
            pad[0] = (s_q.want == '0);
            pad[1] = (s_q.want <= len_t'(1));
            s_d.pairs = s_q.pairs - pair_t'(1);
            s_d.want  = (s_q.want >= len_t'(2)) ? (s_q.want - len_t'(2)) : '0;
        end
        // a new request overrides the rest of the running burst
        if (req) begin
            s_d.pairs = pairs_for(bl_code);
            s_d.want  = eff_len(bl_code, len);
        end
        pend_next = (s_d.pairs != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: every accepted request pulls a pair in the next cycle
    a_r7_req_then_take: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> take);

endmodule

// File: rtl/wbs_strobe.sv
module wbs_strobe
    import wbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       pend_next,
    output logic [1:0] level,
    output logic [1:0] oe
);

    strb_st_t s_d, s_q;
    logic     was_data;

    assign was_data = (s_q.level == 2'b01);

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.level = 2'b01;
            s_d.oe    = 2'b11;
        end else begin
            s_d.level = 2'b00;
            s_d.oe    = {pend_next, pend_next | was_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.level;
    assign oe    = s_q.oe;

    // R10: a taken pair is driven with a rising edge in the following cycle
    a_r10_take_then_edge: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (level == 2'b01));

    // R5: a burst end with nothing pending leaves a low, enabled first half
    a_r5_postamble: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'b01 && !take) |=> (level == 2'b00 && oe[0]));

    // R2: an enabled low second half is always followed by data
    a_r2_preamble_leads: assert property (@(posedge clk) disable iff (!rst_n)
        (oe[1] && level == 2'b00) |=> (level == 2'b01));

endmodule

// File: rtl/wbs_lanes.sv
module wbs_lanes #(
    parameter int DW = 16,
    parameter int MW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [1:0]      pad,
    input  logic [2*DW-1:0] src_data,
    input  logic [2*MW-1:0] src_mask,
    output logic [2*DW-1:0] lane_data,
    output logic [2*MW-1:0] lane_mask
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic [MW-1:0] mask;
    } lane_t;

    for (genvar h = 0; h < 2; h++) begin : g_half
        lane_t l_d, l_q;

        always_comb begin
            l_d = '0;
            if (take) begin
                l_d.data = src_data[h*DW +: DW];
                l_d.mask = src_mask[h*MW +: MW] | {MW{pad[h]}};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) l_q <= '0;
            else        l_q <= l_d;
        end

        assign lane_data[h*DW +: DW] = l_q.data;
        assign lane_mask[h*MW +: MW] = l_q.mask;

        // R9: a padding element leaves the lane fully masked
        a_r9_pad_masked: assert property (@(posedge clk) disable iff (!rst_n)
            (take && pad[h]) |=> (lane_mask[h*MW +: MW] == {MW{1'b1}}));
    end

endmodule

// File: rtl/ddr_wr_strobe_gen.sv
module ddr_wr_strobe_gen
    import wbs_pkg::*;
#(
    parameter  int DW = 16,
    localparam int MW = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [1:0]      wr_bl,
    input  logic [3:0]      wr_len,
    input  logic [2*DW-1:0] src_data,
    input  logic [2*MW-1:0] src_mask,
    output logic            src_take,
    output logic [1:0]      strobe_half,
    output logic [1:0]      strobe_oe,
    output logic [2*DW-1:0] lane_data,
    output logic [2*MW-1:0] lane_mask
);

    logic       take;
    logic [1:0] pad;
    logic       pend_next;

    wbs_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (wr_req),
        .bl_code   (wr_bl),
        .len       (len_t'(wr_len)),
        .take      (take),
        .pad       (pad),
        .pend_next (pend_next)
    );

    wbs_strobe i_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .pend_next (pend_next),
        .level     (strobe_half),
        .oe        (strobe_oe)
    );

    wbs_lanes #(.DW(DW), .MW(MW)) i_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .pad       (pad),
        .src_data  (src_data),
        .src_mask  (src_mask),
        .lane_data (lane_data),
        .lane_mask (lane_mask)
    );

    assign src_take = take;

endmodule

// File: tb/test_ddr_wr_strobe_gen.sv
`timescale 1ns/1ps
module test_ddr_wr_strobe_gen;

    localparam int N = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_bl = '0;
    logic [3:0]  wr_len = '0;
    logic [31:0] src_data = '0;
    logic [3:0]  src_mask = '0;
    logic        src_take;
    logic [1:0]  strobe_half, strobe_oe;
    logic [31:0] lane_data;
    logic [3:0]  lane_mask;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;

    logic        req_a [N];
    logic [1:0]  bl_a  [N];
    logic [3:0]  len_a [N];
    logic [31:0] d_a   [N];
    logic [3:0]  m_a   [N];

    ddr_wr_strobe_gen i_ddr_wr_strobe_gen (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_bl(wr_bl), .wr_len(wr_len),
        .src_data(src_data), .src_mask(src_mask), .src_take(src_take),
        .strobe_half(strobe_half), .strobe_oe(strobe_oe),
        .lane_data(lane_data), .lane_mask(lane_mask)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int pairs_b(logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    function automatic int eff_b(logic [1:0] code, logic [3:0] n);
        int lim = 2 * pairs_b(code);
        return (n == 0 || int'(n) > lim) ? lim : int'(n);
    endfunction

    // latest request before cycle t; it owns t only if its burst still reaches t
    function automatic int owner(int t);
        for (int e = t - 1; e >= 0 && e >= t - 8; e--)
            if (req_a[e]) return (t <= e + pairs_b(bl_a[e])) ? e : -1;
        return -1;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic check_cycle(int c);
        int own, po, j, ef;
        bit nxt, prv;
        string tag;
        logic [3:0] em;
        own = owner(c);
        po  = (c > 0) ? owner(c - 1) : -1;
        nxt = (owner(c + 1) >= 0);
        prv = (po >= 0);
        chk("R10", "take", 64'(src_take), 64'(nxt));
        if (own >= 0) begin
            j  = c - own - 1;
            ef = eff_b(bl_a[own], len_a[own]);
            if (prv && po != own)
                tag = (c <= po + pairs_b(bl_a[po])) ? "R7" : "R6";
            else if (j == 0) tag = "R3";
            else tag = "R4";
            em = m_a[c];
            for (int h = 0; h < 2; h++)
                if (2 * j + h >= ef) em[h*2 +: 2] = 2'b11;
            chk(tag, "strobe", 64'(strobe_half), 64'(2'b01));
            chk(tag, "oe", 64'(strobe_oe), 64'(2'b11));
            chk(tag, "data", 64'(lane_data), 64'(d_a[c]));
            chk("R9", "mask", 64'(lane_mask), 64'(em));
        end else begin
            if (nxt && prv) tag = "R8";
            else if (nxt) tag = "R2";
            else if (prv) tag = "R5";
            else tag = "R1";
            chk(tag, "strobe", 64'(strobe_half), 64'(2'b00));
            chk(tag, "oe", 64'(strobe_oe), 64'({nxt, nxt | prv}));
            chk(tag, "data", 64'(lane_data), 64'(0));
            chk(tag, "mask", 64'(lane_mask), 64'(0));
        end
    endtask

    task automatic step(bit r, logic [1:0] b, logic [3:0] l);
        int c;
        @(negedge clk);
        c = cyc;
        check_cycle(c);
        wr_req = r; wr_bl = b; wr_len = l;
        src_data = $urandom; src_mask = 4'($urandom);
        if (c + 1 < N) begin
            req_a[c+1] = r; bl_a[c+1] = b; len_a[c+1] = l;
            d_a[c+1] = src_data; m_a[c+1] = src_mask;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 4'd0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            req_a[i] = 0; bl_a[i] = 0; len_a[i] = 0; d_a[i] = 0; m_a[i] = 0;
        end
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", "reset outputs",
                64'({src_take, strobe_half, strobe_oe, lane_data, lane_mask}), 64'(0));
        end
        rst_n = 1'b1;
        idle(3);
        // R4: each burst code alone
        step(1, 2'd0, 4'd0); idle(4);
        step(1, 2'd1, 4'd0); idle(5);
        step(1, 2'd2, 4'd0); idle(7);
        step(1, 2'd3, 4'd0); idle(7);
        // R6: joined bursts of four
        step(1, 2'd1, 4'd0); idle(1); step(1, 2'd1, 4'd0); idle(5);
        // R7: truncation after one and after three pairs
        step(1, 2'd2, 4'd0); step(1, 2'd1, 4'd0); idle(5);
        step(1, 2'd2, 4'd0); idle(2); step(1, 2'd0, 4'd0); idle(4);
        // R8: postamble merged into the next preamble
        step(1, 2'd0, 4'd0); idle(1); step(1, 2'd0, 4'd0); idle(4);
        // R9: odd, short, oversized wanted counts
        step(1, 2'd2, 4'd5); idle(7);
        step(1, 2'd1, 4'd3); idle(5);
        step(1, 2'd0, 4'd1); idle(4);
        step(1, 2'd2, 4'd9); idle(7);
        // random mix
        for (int i = 0; i < 2500; i++)
            step(($urandom % 3) == 0, 2'($urandom % 4), 4'($urandom % 10));
        idle(10);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule